// File: doc/BRIEF.md
# Polarity-Selectable PWM Channel

This block drives a single pulse-width-modulated output from an 8-bit counter. The counter advances on a one-cycle enable strobe taken from one of four prescaled tick sources, and a two-bit select input picks the source. The counter is compared against a period value and a duty value. A polarity input sets the level the output holds at the start of each cycle, and the output leaves that level once the counter reaches the duty value. A one-cycle boundary pulse marks the end of every output period.

Two alignments are available. In left-aligned counting the counter climbs from zero and wraps, so one output period lasts `period` ticks. In center-aligned counting it climbs and then descends, so one output period lasts twice as long and the pulse sits symmetrically in the middle. Period and duty pass through shadow registers that load only at a boundary or while the channel is disabled. A new setting therefore never cuts a pulse short. The alignment is latched only while the channel is disabled.

Top module: `pwmch_channel`

## Requirements
- R1: In left-aligned mode with period P ≥ 1, `boundary` pulses once every P ticks of the selected source, on the tick that ends the cycle. After enable, the first pulse comes on the P-th tick.
- R2: Only strobes on `tick_src[clk_sel]` advance the channel. Strobes on the other sources leave `pwm_out` and `boundary` unchanged.
- R3: With `pol`=1 and left-aligned mode, `pwm_out` is high for min(D,P) of every P ticks and starts each period high.
- R4: With `pol`=0 and left-aligned mode, `pwm_out` is high for P−min(D,P) of every P ticks. For example, P=4 and D=1 give 3 high ticks out of 4.
- R5: Duty 0 drives the output steadily to the inverse of `pol`. Duty ≥ P holds it steadily at `pol`.
- R6: Period 0 holds `pwm_out` at `pol` and raises `boundary` on every selected tick.
- R7: With `en`=0, `pwm_out` equals `pol` and the counter returns to zero. After re-enable, a full P ticks pass before the next boundary.
- R8: Period and duty written while the channel runs take effect only after the next boundary. The cycle in progress ends after the old period.
- R9: In center-aligned mode (`center`=1) one cycle lasts 2P ticks and `boundary` pulses once per cycle. The high time is 2·min(D,P) ticks for `pol`=1 and 2·(P−min(D,P)) ticks for `pol`=0.
- R10: `center` is captured only while `en`=0. Changing it on a running channel has no effect until the channel has been disabled.
- R11: `boundary` is high only in a cycle where `en` is high and the selected source strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel run enable |
| pol | input | 1 | Level at the start of each period; also the idle level |
| center | input | 1 | 1 = center-aligned counting, 0 = left-aligned |
| clk_sel | input | 2 | Index of the tick source that drives the counter |
| period | input | 8 | Period value P |
| duty | input | 8 | Duty value D |
| tick_src | input | 4 | One-cycle enable strobes from the prescalers |
| pwm_out | output | 1 | PWM output |
| boundary | output | 1 | One-cycle pulse at the end of each output period |

## Verification
The bound checker watches several properties on every cycle:
- the counter holds between selected strobes;
- the counter stays below the loaded period;
- the shadow registers stay stable except at a boundary or while disabled;
- `boundary` appears only together with a selected strobe;
- a disabled channel clears its counter;
- the constant-level duty cases hold.

High-time counts, the period length in both alignments, the delayed take-over of new period and duty values, and the refusal to switch alignment while running depend on sequences of ticks. Only the bench's sweeps over period, duty, polarity and source can show those.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;

   typedef enum logic {
      ALIGN_LEFT   = 1'b0,
      ALIGN_CENTER = 1'b1
   } align_e;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } dir_e;

endpackage

// File: rtl/pwmch_tick_sel.sv
module pwmch_tick_sel #(
   parameter int NUM_SRC = 4,
   parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] src,
   input  logic [SEL_W-1:0]   sel,
   output logic               tick
);

   localparam int FULL_DECODE = (NUM_SRC == (1 << SEL_W)) ? 1 : 0;

   if (NUM_SRC < 2) begin : g_bad_src
      $error("pwmch_tick_sel: NUM_SRC must be at least 2");
   end

   if (FULL_DECODE == 1) begin : g_full
      assign tick = src[sel];
   end else begin : g_part
      always_comb begin
         tick = 1'b0;
         for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(sel) == i) tick = src[i];
         end
      end
   end

endmodule

// File: rtl/pwmch_shadow.sv
module pwmch_shadow #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] per_in,
   input  logic [CNT_W-1:0] duty_in,
   output logic [CNT_W-1:0] per_q,
   output logic [CNT_W-1:0] duty_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q  <= '0;
         duty_q <= '0;
      end else if (load) begin
         per_q  <= per_in;
         duty_q <= duty_in;
      end
   end

endmodule

// File: rtl/pwmch_counter.sv
module pwmch_counter
   import pwmch_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter bit HAS_CENTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  align_e           align,
   input  logic [CNT_W-1:0] per_q,
   output logic [CNT_W-1:0] cnt,
   output logic             at_end
);

   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;

   logic per_zero;
   logic top_reached;
   assign per_zero    = (per_q == CNT_ZERO);
   assign top_reached = !per_zero && (cnt >= (per_q - CNT_ONE));

   if (HAS_CENTER) begin : g_dual
      dir_e dir_q;
      logic end_left, end_center;

      assign end_left   = per_zero || top_reached;
      assign end_center = per_zero || ((dir_q == DIR_DOWN) && (cnt == CNT_ZERO));
      assign at_end     = (align == ALIGN_CENTER) ? end_center : end_left;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt   <= CNT_ZERO;
            dir_q <= DIR_UP;
         end else if (!en) begin
            cnt   <= CNT_ZERO;
            dir_q <= DIR_UP;
         end else if (tick) begin
            if (per_zero) begin
               cnt   <= CNT_ZERO;
               dir_q <= DIR_UP;
            end else if (align == ALIGN_LEFT) begin
               dir_q <= DIR_UP;
               cnt   <= top_reached ? CNT_ZERO : cnt + CNT_ONE;
            end else if (dir_q == DIR_UP) begin
               if (top_reached) dir_q <= DIR_DOWN;
               else             cnt   <= cnt + CNT_ONE;
            end else begin
               if (cnt == CNT_ZERO) dir_q <= DIR_UP;
               else                 cnt   <= cnt - CNT_ONE;
            end
         end
      end
   end else begin : g_left
      logic unused_align;
      assign unused_align = align;
      assign at_end       = per_zero || top_reached;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt <= CNT_ZERO;
         else if (!en)    cnt <= CNT_ZERO;
         else if (tick)   cnt <= at_end ? CNT_ZERO : cnt + CNT_ONE;
      end
   end

endmodule

// File: rtl/pwmch_wave.sv
module pwmch_wave #(
   parameter int CNT_W = 8
) (
   input  logic             en,
   input  logic             pol,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] per_q,
   input  logic [CNT_W-1:0] duty_q,
   output logic             wave
);

   logic past_duty;
   assign past_duty = (per_q != '0) && (cnt >= duty_q);
   assign wave      = (en && past_duty) ? ~pol : pol;

endmodule

// File: rtl/pwmch_channel.sv
module pwmch_channel
   import pwmch_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int NUM_SRC    = 4,
   parameter bit HAS_CENTER = 1'b1,
   parameter int SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               pol,
   input  logic               center,
   input  logic [SEL_W-1:0]   clk_sel,
   input  logic [CNT_W-1:0]   period,
   input  logic [CNT_W-1:0]   duty,
   input  logic [NUM_SRC-1:0] tick_src,
   output logic               pwm_out,
   output logic               boundary
);

   if (CNT_W < 2) begin : g_bad_width
      $error("pwmch_channel: CNT_W must be at least 2");
   end

   logic             tick;
   logic             at_end;
   logic             load;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] duty_q;
   align_e           align_q;

   if (HAS_CENTER) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   align_q <= ALIGN_LEFT;
         else if (!en) align_q <= align_e'(center);
      end
   end else begin : g_nomode
      logic unused_center;
      assign unused_center = center;
      assign align_q       = ALIGN_LEFT;
   end

   pwmch_tick_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
      .src  (tick_src),
      .sel  (clk_sel),
      .tick (tick)
   );

   assign boundary = en && tick && at_end;
   assign load     = !en || boundary;

   pwmch_shadow #(.CNT_W(CNT_W)) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .per_in  (period),
      .duty_in (duty),
      .per_q   (per_q),
      .duty_q  (duty_q)
   );

   pwmch_counter #(.CNT_W(CNT_W), .HAS_CENTER(HAS_CENTER)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .tick   (tick),
      .align  (align_q),
      .per_q  (per_q),
      .cnt    (cnt_w),
      .at_end (at_end)
   );

   pwmch_wave #(.CNT_W(CNT_W)) u_wave (
      .en     (en),
      .pol    (pol),
      .cnt    (cnt_w),
      .per_q  (per_q),
      .duty_q (duty_q),
      .wave   (pwm_out)
   );

endmodule

// File: rtl/pwmch_channel_chk.sv
module pwmch_channel_chk #(
   parameter int CNT_W   = 8,
   parameter int NUM_SRC = 4,
   parameter int SEL_W   = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en,
   input logic               pol,
   input logic [SEL_W-1:0]   clk_sel,
   input logic [NUM_SRC-1:0] tick_src,
   input logic               boundary,
   input logic               pwm_out,
   input logic [CNT_W-1:0]   cnt,
   input logic [CNT_W-1:0]   per_q,
   input logic [CNT_W-1:0]   duty_q
);

   AST_BND_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |-> (en && tick_src[clk_sel])); // R11

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick_src[clk_sel]) |=> $stable(cnt)); // R2

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && per_q != '0) |-> (cnt < per_q)); // R1

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !boundary) |=> ($stable(per_q) && $stable(duty_q))); // R8

   AST_DIS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0)); // R7

   AST_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (en && per_q != '0 && duty_q >= per_q) |-> (pwm_out == pol)); // R5

   AST_PER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (per_q == '0) |-> (pwm_out == pol)); // R6

endmodule

bind pwmch_channel pwmch_channel_chk #(
   .CNT_W(CNT_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .pol      (pol),
   .clk_sel  (clk_sel),
   .tick_src (tick_src),
   .boundary (boundary),
   .pwm_out  (pwm_out),
   .cnt      (cnt_w),
   .per_q    (per_q),
   .duty_q   (duty_q)
);

// File: tb/pwmch_channel_bench.sv
module pwmch_channel_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       pol = 1'b0;
   logic       center = 1'b0;
   logic [1:0] clk_sel = 2'd0;
   logic [7:0] period = 8'd0;
   logic [7:0] duty = 8'd0;
   logic [3:0] tick_src = 4'd0;
   logic       pwm_out;
   logic       boundary;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwmch_channel u_pwmch_channel (
      .clk(clk), .rst_n(rst_n), .en(en), .pol(pol), .center(center),
      .clk_sel(clk_sel), .period(period), .duty(duty), .tick_src(tick_src),
      .pwm_out(pwm_out), .boundary(boundary)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic [3:0] mask, output logic ob, output logic bb);
      @(negedge clk);
      ob = pwm_out;
      tick_src = mask;
      #1 bb = boundary;
      @(negedge clk);
      tick_src = 4'd0;
   endtask

   task automatic window(input int n, output int highs, output int bnds, output logic last_b);
      logic ob, bb;
      highs = 0; bnds = 0; last_b = 1'b0;
      for (int i = 0; i < n; i++) begin
         step(4'd1 << clk_sel, ob, bb);
         highs += int'(ob);
         bnds  += int'(bb);
         last_b = bb;
      end
   endtask

   task automatic setup(input int p, input int d, input logic pl, input logic c, input int s);
      @(negedge clk);
      en = 1'b0; period = 8'(p); duty = 8'(d); pol = pl; center = c; clk_sel = 2'(s);
      repeat (2) @(negedge clk);
      en = 1'b1;
   endtask

   function automatic int min2(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   initial begin
      int h, b, eh;
      logic lb, ob, bb;
      pol = 1'b1;
      repeat (3) @(negedge clk);
      chk(pwm_out == 1'b1, "R7 reset level", int'(pwm_out), 1);
      chk(boundary == 1'b0, "R11 reset boundary", int'(boundary), 0);
      rst_n = 1'b1;

      // R1 R3 R4 R5: left-aligned sweep
      for (int p = 1; p <= 6; p++) begin
         for (int d = 0; d <= 7; d++) begin
            for (int pl = 0; pl < 2; pl++) begin
               setup(p, d, pl[0], 1'b0, (p + d) % 4);
               window(2 * p, h, b, lb);
               eh = pl ? 2 * min2(d, p) : 2 * (p - min2(d, p));
               chk(h == eh, pl ? "R3 high ticks" : "R4 high ticks", h, eh);
               chk(b == 2 && lb, "R1 boundary count", b, 2);
            end
         end
      end

      // R9: center-aligned sweep
      for (int p = 1; p <= 5; p++) begin
         for (int d = 0; d <= 6; d++) begin
            for (int pl = 0; pl < 2; pl++) begin
               setup(p, d, pl[0], 1'b1, (p + 2 * d) % 4);
               window(2 * p, h, b, lb);
               eh = pl ? 2 * min2(d, p) : 2 * (p - min2(d, p));
               chk(h == eh, "R9 center high ticks", h, eh);
               chk(b == 1 && lb, "R9 center boundary", b, 1);
            end
         end
      end

      // R5 explicit: duty 0 constant inverse of pol
      setup(5, 0, 1'b0, 1'b0, 1);
      window(5, h, b, lb);
      chk(h == 5, "R5 duty zero", h, 5);

      // R6: period 0
      for (int pl = 0; pl < 2; pl++) begin
         setup(0, 0, pl[0], 1'b0, 2);
         window(4, h, b, lb);
         chk(h == (pl ? 4 : 0), "R6 period zero level", h, pl ? 4 : 0);
         chk(b == 4, "R6 period zero boundary", b, 4);
      end

      // R2 R11: other sources ignored
      setup(2, 1, 1'b0, 1'b0, 1);
      for (int i = 0; i < 6; i++) begin
         step(4'b1101, ob, bb);
         chk(bb == 1'b0, "R11 no boundary without selected tick", int'(bb), 0);
      end
      chk(pwm_out == 1'b0, "R2 output unchanged", int'(pwm_out), 0);
      step(4'b0010, ob, bb);
      #1 chk(pwm_out == 1'b1, "R2 selected tick advances", int'(pwm_out), 1);

      // R7: disable mid-period
      setup(5, 2, 1'b0, 1'b0, 3);
      window(3, h, b, lb);
      chk(pwm_out == 1'b1, "R7 running high", int'(pwm_out), 1);
      en = 1'b0;
      #1 chk(pwm_out == 1'b0, "R7 disabled level", int'(pwm_out), 0);
      repeat (2) @(negedge clk);
      en = 1'b1;
      window(4, h, b, lb);
      chk(b == 0, "R7 no early boundary", b, 0);
      window(1, h, b, lb);
      chk(b == 1, "R7 boundary after full period", b, 1);

      // R8: shadowed period and duty
      setup(4, 2, 1'b0, 1'b0, 0);
      window(1, h, b, lb);
      period = 8'd6; duty = 8'd1;
      window(2, h, b, lb);
      chk(b == 0, "R8 old cycle continues", b, 0);
      window(1, h, b, lb);
      chk(b == 1, "R8 old period ends", b, 1);
      window(6, h, b, lb);
      chk(h == 5, "R8 new duty high ticks", h, 5);
      chk(b == 1 && lb, "R8 new period length", b, 1);

      // R10: alignment latched only while disabled
      setup(3, 1, 1'b0, 1'b0, 2);
      center = 1'b1;
      window(3, h, b, lb);
      chk(b == 1 && lb, "R10 stays left aligned", b, 1);
      chk(h == 2, "R10 left high ticks", h, 2);
      setup(3, 1, 1'b0, 1'b1, 2);
      window(6, h, b, lb);
      chk(b == 1 && lb, "R10 center after disable", b, 1);
      chk(h == 4, "R10 center high ticks", h, 4);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule